// File: doc/BRIEF.md
# Configurable I/O Pad Router

This block connects a set of peripheral function signals to a smaller set of physical I/O pads under register control. Every pad has a selector register holding a binary function index. The selected function drives the pad's output level and output enable. Function index 0 is a general-purpose I/O function whose per-pad level and direction come from registers. The other functions are peripherals: output-only, input-only, or bidirectional with the direction driven by the peripheral itself, so a bus group can gang its own direction.

In the other direction, every function input has its own priority selector with one enable bit per pad. Among the pads that are enabled for that function and whose output enable is low, the lowest-indexed pad is routed to the function. If no pad qualifies, the function sees a programmable idle level. Several pads mapped to one function input therefore never contend. One function may drive several pads, and one pad may feed several functions.

Configuration registers sit behind a single-cycle write port and a combinational read port. Pad electrical settings and interrupts are handled elsewhere.

Top module: `pad_router`

## Requirements
- R1: Pad p's output level is the register bit `gpio_level[p]` (address NUM_PADS+NUM_FUNCS) when its selector holds 0, and `fn_out[s]` when its selector holds a function s that is not input-only.
- R2: Pad p's output enable is the register bit `gpio_dir[p]` (address NUM_PADS+NUM_FUNCS+1, 1 = drive) when its selector holds 0, and `fn_oe[s]` when it holds a function s that is not input-only, so that a bus or bidirectional function controls its own direction.
- R3: When a pad's selector holds a function marked in the parameter FN_INPUT_ONLY (function 3 by default), both its output level and its output enable are 0.
- R4: `fn_in[f]` equals `pad_in[p]` for the lowest index p whose bit p is set in function f's input-enable register (address NUM_PADS+f) and whose pad output enable is 0.
- R5: A pad whose output enable is 1 takes no part in any function's input selection, whatever its level and its enable bit.
- R6: When no pad qualifies for function f, `fn_in[f]` equals bit f of the idle register (address NUM_PADS+NUM_FUNCS+2).
- R7: One function may drive several pads at once, and one pad may feed several function inputs at once.
- R8: After reset, every selector, every input-enable register, `gpio_level` and `gpio_dir` are 0, and the idle register holds IDLE_INIT (all ones by default). So every pad selects function 0 as an input and every function input reads 1.
- R9: A write with `reg_we` high at a clock edge updates the register at `reg_addr` (pad selectors at addresses 0..NUM_PADS-1, value in the low SEL_W bits). The new value is visible on `reg_rdata` after that edge. Writes to unmapped addresses change nothing, and unmapped addresses read 0.
- R10: Address NUM_PADS+NUM_FUNCS+3 is read-only and returns the current `pad_in` levels in its low bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| fn_out | input | 2**SEL_W | Output level from each function |
| fn_oe | input | 2**SEL_W | Output enable requested by each function |
| fn_in | output | 2**SEL_W | Input level delivered to each function |
| pad_in | input | NUM_PADS | Level sensed at each pad |
| pad_out | output | NUM_PADS | Level driven to each pad |
| pad_oe | output | NUM_PADS | Output enable of each pad |

## Verification
The bench uses the default build: four pads and a 2-bit selector, so four functions with function 3 input-only. At this size the output side is swept over all 256 selector combinations, each crossed with sixteen function level and enable patterns. The input side is swept over sixteen enable-mask sets, all sixteen direction masks and all sixteen pad level patterns. Every priority position, every skip of a driven pad and every idle fallback is therefore reached, along with the whole register map and its unmapped addresses.

// File: rtl/pmx_pkg.sv
// Shared definitions for the pad router.
// Assumes: function slot 0 is always the register-controlled GPIO function.
package pmx_pkg;

    // Function slot that takes its pad level and direction from registers
    localparam int unsigned PMX_GPIO_SLOT = 0;

    // Class of register addressed by the configuration port
    typedef enum logic [2:0] {
        RK_SEL,
        RK_INEN,
        RK_GLEVEL,
        RK_GDIR,
        RK_IDLE,
        RK_GIN,
        RK_NONE
    } reg_kind_e;

endpackage

// File: rtl/pmx_regs.sv
// Configuration register file of the pad router.
// Holds the per-pad selectors, the per-function input-enable masks, the GPIO
// level and direction, and the per-function idle levels.
// Assumes: DATA_W >= NUM_PADS, DATA_W >= NUM_FUNCS, DATA_W >= SEL_W.
module pmx_regs
    import pmx_pkg::*;
#(
    parameter int unsigned NUM_PADS  = 4,
    parameter int unsigned SEL_W     = 2,
    parameter int unsigned NUM_FUNCS = 4,
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned DATA_W    = 8,
    parameter logic [NUM_FUNCS-1:0] IDLE_INIT = '1
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 we,
    input  logic [ADDR_W-1:0]                    addr,
    input  logic [DATA_W-1:0]                    wdata,
    output logic [DATA_W-1:0]                    rdata,
    input  logic [NUM_PADS-1:0]                  pad_in,
    output logic [NUM_PADS-1:0][SEL_W-1:0]       sel_o,
    output logic [NUM_FUNCS-1:0][NUM_PADS-1:0]   inen_o,
    output logic [NUM_PADS-1:0]                  glevel_o,
    output logic [NUM_PADS-1:0]                  gdir_o,
    output logic [NUM_FUNCS-1:0]                 idle_o
);

    localparam int unsigned INEN_BASE   = NUM_PADS;
    localparam int unsigned GLEVEL_ADDR = NUM_PADS + NUM_FUNCS;
    localparam int unsigned GDIR_ADDR   = GLEVEL_ADDR + 1;
    localparam int unsigned IDLE_ADDR   = GLEVEL_ADDR + 2;
    localparam int unsigned GIN_ADDR    = GLEVEL_ADDR + 3;

    logic [NUM_PADS-1:0][SEL_W-1:0]     sel_q;
    logic [NUM_FUNCS-1:0][NUM_PADS-1:0] inen_q;
    logic [NUM_PADS-1:0]                glevel_q;
    logic [NUM_PADS-1:0]                gdir_q;
    logic [NUM_FUNCS-1:0]               idle_q;

    reg_kind_e   kind;
    int unsigned idx;
    int unsigned a;
    logic        unused_wdata;

    assign unused_wdata = ^wdata;

    // Decode the address into a register class and an index within the class
    always_comb begin
        a    = 32'(addr);
        kind = RK_NONE;
        idx  = 0;
        if (a < INEN_BASE) begin
            kind = RK_SEL;
            idx  = a;
        end else if (a < GLEVEL_ADDR) begin
            kind = RK_INEN;
            idx  = a - INEN_BASE;
        end else if (a == GLEVEL_ADDR) begin
            kind = RK_GLEVEL;
        end else if (a == GDIR_ADDR) begin
            kind = RK_GDIR;
        end else if (a == IDLE_ADDR) begin
            kind = RK_IDLE;
        end else if (a == GIN_ADDR) begin
            kind = RK_GIN;
        end
    end

    // Reset all configuration, then apply writes to the decoded register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q    <= '0;
            inen_q   <= '0;
            glevel_q <= '0;
            gdir_q   <= '0;
            idle_q   <= IDLE_INIT;
        end else if (we) begin
            for (int unsigned p = 0; p < NUM_PADS; p++) begin
                if (kind == RK_SEL && idx == p) sel_q[p] <= wdata[SEL_W-1:0];
            end
            for (int unsigned f = 0; f < NUM_FUNCS; f++) begin
                if (kind == RK_INEN && idx == f) inen_q[f] <= wdata[NUM_PADS-1:0];
            end
            if (kind == RK_GLEVEL) glevel_q <= wdata[NUM_PADS-1:0];
            if (kind == RK_GDIR)   gdir_q   <= wdata[NUM_PADS-1:0];
            if (kind == RK_IDLE)   idle_q   <= wdata[NUM_FUNCS-1:0];
        end
    end

    // Return the addressed register zero-extended; unmapped addresses read 0
    always_comb begin
        rdata = '0;
        unique case (kind)
            RK_SEL: begin
                for (int unsigned p = 0; p < NUM_PADS; p++)
                    if (idx == p) rdata[SEL_W-1:0] = sel_q[p];
            end
            RK_INEN: begin
                for (int unsigned f = 0; f < NUM_FUNCS; f++)
                    if (idx == f) rdata[NUM_PADS-1:0] = inen_q[f];
            end
            RK_GLEVEL: rdata[NUM_PADS-1:0]  = glevel_q;
            RK_GDIR:   rdata[NUM_PADS-1:0]  = gdir_q;
            RK_IDLE:   rdata[NUM_FUNCS-1:0] = idle_q;
            RK_GIN:    rdata[NUM_PADS-1:0]  = pad_in;
            default:   rdata = '0;
        endcase
    end

    assign sel_o    = sel_q;
    assign inen_o   = inen_q;
    assign glevel_o = glevel_q;
    assign gdir_o   = gdir_q;
    assign idle_o   = idle_q;

    // A selector write is held in the register after the edge
    for (genvar gp = 0; gp < NUM_PADS; gp++) begin : g_sel_chk
        AST_SEL_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (we && addr == ADDR_W'(gp)) |=> (sel_q[gp] == $past(wdata[SEL_W-1:0]))); // R9
    end

    // Leaving reset, the configuration holds its reset values
    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sel_q == '0 && inen_q == '0 && gdir_q == '0 && idle_q == IDLE_INIT)); // R8

endmodule

// File: rtl/pmx_out_mux.sv
// Output selector of one pad: picks the level and output enable of the
// function addressed by the pad's selector.
// Assumes: NUM_FUNCS == 2**SEL_W so every selector value names a function.
module pmx_out_mux
    import pmx_pkg::*;
#(
    parameter int unsigned SEL_W     = 2,
    parameter int unsigned NUM_FUNCS = 4,
    parameter logic [NUM_FUNCS-1:0] INPUT_ONLY = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SEL_W-1:0]     sel,
    input  logic [NUM_FUNCS-1:0] fn_out,
    input  logic [NUM_FUNCS-1:0] fn_oe,
    input  logic                 gpio_level,
    input  logic                 gpio_dir,
    output logic                 pad_out,
    output logic                 pad_oe
);

    logic sel_is_gpio;
    logic sel_is_input_only;

    assign sel_is_gpio       = (sel == SEL_W'(PMX_GPIO_SLOT));
    assign sel_is_input_only = INPUT_ONLY[sel];

    // Route GPIO registers, silence input-only functions, pass the rest through
    always_comb begin
        if (sel_is_gpio) begin
            pad_out = gpio_level;
            pad_oe  = gpio_dir;
        end else if (sel_is_input_only) begin
            pad_out = 1'b0;
            pad_oe  = 1'b0;
        end else begin
            pad_out = fn_out[sel];
            pad_oe  = fn_oe[sel];
        end
    end

    // An input-only selection never drives the pad
    AST_INPUT_ONLY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_is_gpio && INPUT_ONLY[sel]) |-> (!pad_oe && !pad_out)); // R3

endmodule

// File: rtl/pmx_in_prio.sv
// Input priority selector of one function: among the pads enabled for the
// function and not currently driving, the lowest-indexed one is routed in.
// Assumes: a pad with its output enable high has its input receiver off.
module pmx_in_prio #(
    parameter int unsigned NUM_PADS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PADS-1:0] en,
    input  logic [NUM_PADS-1:0] pad_oe,
    input  logic [NUM_PADS-1:0] pad_in,
    input  logic                idle,
    output logic                fn_in
);

    logic [NUM_PADS-1:0] elig;
    logic [NUM_PADS-1:0] grant;

    // Keep only enabled pads whose receiver is active
    assign elig  = en & ~pad_oe;
    // Isolate the lowest set bit as a one-hot grant
    assign grant = elig & (~elig + NUM_PADS'(1));

    // Deliver the granted pad level, or the idle level when nothing qualifies
    always_comb begin
        if (elig != '0) fn_in = |(grant & pad_in);
        else            fn_in = idle;
    end

    // At most one pad is ever routed to the function
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R4

    // A driving pad is never the one routed in
    AST_SKIP_DRIVEN_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & pad_oe) == '0); // R5

    // With no qualifying pad the function sees its idle level
    AST_IDLE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (en & ~pad_oe) == '0 |-> fn_in == idle); // R6

endmodule

// File: rtl/pad_router.sv
// Top of the pad router: register file, one output selector per pad and one
// input priority selector per function.
// Assumes: function 0 is GPIO; functions marked in FN_INPUT_ONLY never drive.
module pad_router #(
    parameter int unsigned NUM_PADS = 4,
    parameter int unsigned SEL_W    = 2,
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned DATA_W   = 8,
    parameter logic [(2**SEL_W)-1:0] FN_INPUT_ONLY = 4'b1000,
    parameter logic [(2**SEL_W)-1:0] IDLE_INIT     = '1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_we,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [DATA_W-1:0]        reg_wdata,
    output logic [DATA_W-1:0]        reg_rdata,
    input  logic [(2**SEL_W)-1:0]    fn_out,
    input  logic [(2**SEL_W)-1:0]    fn_oe,
    output logic [(2**SEL_W)-1:0]    fn_in,
    input  logic [NUM_PADS-1:0]      pad_in,
    output logic [NUM_PADS-1:0]      pad_out,
    output logic [NUM_PADS-1:0]      pad_oe
);

    localparam int unsigned NUM_FUNCS = 2 ** SEL_W;

    logic [NUM_PADS-1:0][SEL_W-1:0]     sel;
    logic [NUM_FUNCS-1:0][NUM_PADS-1:0] inen;
    logic [NUM_PADS-1:0]                glevel;
    logic [NUM_PADS-1:0]                gdir;
    logic [NUM_FUNCS-1:0]               idle;

    // Configuration registers and read port
    pmx_regs #(
        .NUM_PADS  (NUM_PADS),
        .SEL_W     (SEL_W),
        .NUM_FUNCS (NUM_FUNCS),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .IDLE_INIT (IDLE_INIT)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .pad_in   (pad_in),
        .sel_o    (sel),
        .inen_o   (inen),
        .glevel_o (glevel),
        .gdir_o   (gdir),
        .idle_o   (idle)
    );

    // One output selector per pad
    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        pmx_out_mux #(
            .SEL_W      (SEL_W),
            .NUM_FUNCS  (NUM_FUNCS),
            .INPUT_ONLY (FN_INPUT_ONLY)
        ) u_out (
            .clk        (clk),
            .rst_n      (rst_n),
            .sel        (sel[p]),
            .fn_out     (fn_out),
            .fn_oe      (fn_oe),
            .gpio_level (glevel[p]),
            .gpio_dir   (gdir[p]),
            .pad_out    (pad_out[p]),
            .pad_oe     (pad_oe[p])
        );
    end

    // One input priority selector per function
    for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_fn
        pmx_in_prio #(
            .NUM_PADS (NUM_PADS)
        ) u_in (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (inen[f]),
            .pad_oe (pad_oe),
            .pad_in (pad_in),
            .idle   (idle[f]),
            .fn_in  (fn_in[f])
        );
    end

endmodule

// File: tb/tb_pad_router.sv
`timescale 1ns/1ps
module tb_pad_router;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [3:0] fn_out = '0;
    logic [3:0] fn_oe = '0;
    logic [3:0] fn_in;
    logic [3:0] pad_in = '0;
    logic [3:0] pad_out;
    logic [3:0] pad_oe;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pad_router dut (
        .clk(clk), .rst_n(rst_n),
        .reg_we(we), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
        .fn_out(fn_out), .fn_oe(fn_oe), .fn_in(fn_in),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        we = 1'b1; addr = 4'(a); wdata = 8'(d);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd_chk(input int a, input int exp, input string tag);
        addr = 4'(a);
        #1;
        chk(rdata == 8'(exp), tag, rdata, exp);
    endtask

    // Expected input for one function from its requirement definition
    function automatic bit exp_in(input logic [3:0] en, input logic [3:0] oe,
                                  input logic [3:0] pin, input bit idle);
        for (int p = 0; p < 4; p++)
            if (en[p] && !oe[p]) return pin[p];
        return idle;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0] exp_o, exp_e, exp_f;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: reset state
        #1;
        chk(pad_oe == 4'h0, "R8 pad_oe after reset", pad_oe, 0);
        chk(pad_out == 4'h0, "R8 pad_out after reset", pad_out, 0);
        chk(fn_in == 4'hF, "R8 fn_in idle after reset", fn_in, 15);
        for (int a = 0; a < 10; a++) rd_chk(a, 0, "R8 register reset value");
        rd_chk(10, 15, "R8 idle register reset value");

        // R9: write and read back every register, then unmapped addresses
        for (int a = 0; a < 4; a++) wr(a, (a + 1) & 3);
        for (int a = 4; a < 8; a++) wr(a, 16'hA5 >> (a - 4));
        wr(8, 8'h9); wr(9, 8'h6); wr(10, 8'h3);
        for (int a = 0; a < 4; a++) rd_chk(a, (a + 1) & 3, "R9 selector readback");
        for (int a = 4; a < 8; a++) rd_chk(a, (16'hA5 >> (a - 4)) & 15, "R9 input enable readback");
        rd_chk(8, 9, "R9 gpio level readback");
        rd_chk(9, 6, "R9 gpio dir readback");
        rd_chk(10, 3, "R9 idle readback");
        for (int a = 12; a < 16; a++) wr(a, 8'hFF);
        for (int a = 12; a < 16; a++) rd_chk(a, 0, "R9 unmapped reads zero");
        rd_chk(0, 1, "R9 unmapped write left selector");
        rd_chk(8, 9, "R9 unmapped write left gpio level");
        rd_chk(10, 3, "R9 unmapped write left idle");

        // R10: live pad levels through the read-only register
        for (int v = 0; v < 16; v++) begin
            pad_in = 4'(v);
            rd_chk(11, v, "R10 pad level read");
        end
        pad_in = '0;

        // R1 R2 R3: every selector combination against function patterns
        for (int cfg = 0; cfg < 256; cfg++) begin
            for (int p = 0; p < 4; p++) wr(p, (cfg >> (2 * p)) & 3);
            wr(8, (cfg >> 4) ^ cfg);
            wr(9, cfg);
            for (int k = 0; k < 16; k++) begin
                fn_out = 4'(k);
                fn_oe  = 4'(k ^ cfg ^ 6);
                #1;
                for (int p = 0; p < 4; p++) begin
                    int s;
                    s = (cfg >> (2 * p)) & 3;
                    if (s == 0) begin
                        exp_o[p] = 1'((((cfg >> 4) ^ cfg) >> p) & 1);
                        exp_e[p] = 1'((cfg >> p) & 1);
                    end else if (s == 3) begin
                        exp_o[p] = 1'b0;
                        exp_e[p] = 1'b0;
                    end else begin
                        exp_o[p] = fn_out[s];
                        exp_e[p] = fn_oe[s];
                    end
                end
                chk(pad_out == exp_o, "R1 R3 pad output level", pad_out, exp_o);
                chk(pad_oe == exp_e, "R2 R3 pad output enable", pad_oe, exp_e);
            end
        end

        // R7: one function driving all pads
        for (int p = 0; p < 4; p++) wr(p, 2);
        fn_out = 4'b0100; fn_oe = 4'b0100;
        #1;
        chk(pad_out == 4'hF && pad_oe == 4'hF, "R7 one function to all pads", {pad_oe, pad_out}, 8'hFF);
        fn_out = 4'b0000;
        #1;
        chk(pad_out == 4'h0 && pad_oe == 4'hF, "R7 one function to all pads low", {pad_oe, pad_out}, 8'hF0);

        // R4 R5 R6: input priority over enables, directions and pad levels
        for (int p = 0; p < 4; p++) wr(p, 0);
        for (int m = 0; m < 16; m++) begin
            for (int dir = 0; dir < 16; dir++) begin
                for (int f = 0; f < 4; f++) wr(4 + f, (m * (f + 1) + f) & 15);
                wr(9, dir);
                wr(10, (m + dir) & 15);
                for (int v = 0; v < 16; v++) begin
                    pad_in = 4'(v);
                    #1;
                    for (int f = 0; f < 4; f++) begin
                        logic [3:0] en;
                        en = 4'((m * (f + 1) + f) & 15);
                        exp_f[f] = exp_in(en, 4'(dir), 4'(v), 1'(((m + dir) >> f) & 1));
                        if ((en & ~4'(dir)) == 4'h0)
                            chk(fn_in[f] == exp_f[f], "R6 idle level", fn_in[f], exp_f[f]);
                        else if ((en & 4'(dir)) != 4'h0)
                            chk(fn_in[f] == exp_f[f], "R5 driven pad skipped", fn_in[f], exp_f[f]);
                        else
                            chk(fn_in[f] == exp_f[f], "R4 lowest pad wins", fn_in[f], exp_f[f]);
                    end
                end
            end
        end

        // R7: one pad feeding every function
        for (int f = 0; f < 4; f++) wr(4 + f, 4'b0010);
        wr(9, 0);
        wr(10, 0);
        pad_in = 4'b0010;
        #1;
        chk(fn_in == 4'hF, "R7 one pad to all functions high", fn_in, 15);
        pad_in = 4'b1101;
        #1;
        chk(fn_in == 4'h0, "R7 one pad to all functions low", fn_in, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule